// File: doc/BRIEF.md
# Left-Justified Stereo Serial Audio Transmitter

This block sends stereo samples one bit at a time in left-justified form. A bit clock and a frame-sync come from outside the block and are only observed. One frame-sync level frames the first (left) channel and the other level frames the second. A word goes out MSB first, starting in the bit period that follows a frame-sync transition, with no extra delay bit. Once the word ends, the rest of the half-frame is padded with zeros.

A parallel producer fills a one-word holding buffer through a valid/ready handshake, in place of a DMA request. The buffer passes its word to the shift register only at a frame-sync edge. This creates a known start-up hazard. If the port is enabled while the buffer is still empty, the first edge sends a stale word. The first real sample then has to wait for the opposite edge, and from then on left and right are swapped.

The block flags that hazard. It also reports buffer underruns and tags each word as left or right.

Top module: `lj_audio_tx`

## Requirements
- R1: A word is sent MSB first on `sdata_o`, and its MSB appears in the first bit-clock period after a frame-sync transition. The output changes only after a falling bit-clock edge. Both `fs_in` and the bit clock change together at the falling edge.
- R2: After the last bit of a word, `sdata_o` is 0 for the rest of the half-frame. It is also 0 whenever `port_en` is 0.
- R3: Once `port_en` is set, output starts only at a first-channel edge. That is a rising `fs_in` edge when `first_on_fall`=0, and a falling one when it is 1. A non-qualifying edge before the start sends nothing and leaves the buffer full.
- R4: The holding buffer hands its word to the shift register only at a frame-sync edge. A word written in the middle of a half-frame waits in the buffer, with `wr_ready`=0, until the next edge.
- R5: `underrun_o` is set when a frame-sync edge arrives during transmission while the buffer is empty. It stays set until `err_clr` is pulsed or `port_en` goes to 0.
- R6: On an underrun, the half-frame repeats the last word that was loaded, or sends all zeros if no word has been loaded since reset.
- R7: `chan_o` reports the word being sent: 0 when it was framed by a first-channel edge, 1 when framed by the opposite edge.
- R8: `swap_o` is set if the first non-underrun word after enable starts on a non-first-channel edge. It is cleared by `err_clr` or by clearing `port_en`.
- R9: While `fill_en` is 0, `wr_ready` is 0 and no word is taken in, even if `wr_valid` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | External bit clock |
| fs_in | input | 1 | External frame-sync |
| port_en | input | 1 | Port enable |
| fill_en | input | 1 | Buffer-fill enable |
| first_on_fall | input | 1 | 1: the first channel is framed by a falling frame-sync edge |
| err_clr | input | 1 | Clears the underrun and swap flags |
| wr_valid | input | 1 | Producer word valid |
| wr_data | input | WORD_W | Producer word |
| wr_ready | output | 1 | The buffer can take a word |
| sdata_o | output | 1 | Serial data |
| chan_o | output | 1 | Channel tag of the current word |
| underrun_o | output | 1 | Sticky underrun flag |
| swap_o | output | 1 | Sticky channel-swap flag |

## Verification
A falling bit-clock edge reaches `sdata_o`, `chan_o` and the flags on the third rising system-clock edge after it: two synchroniser stages, then the output register. The bench keeps each bit-clock phase four system clocks long. It reads each serial bit seven system clocks after the falling edge that launched it, which is well past that latency and before the next fall.

`wr_ready` drops one cycle after a handshake. The bench checks it several cycles later. It reads flags and tags only after a complete half-frame.

// File: rtl/lj_tx_pkg.sv
package lj_tx_pkg;
  typedef enum logic {
    CH_FIRST  = 1'b0,
    CH_SECOND = 1'b1
  } chan_e;

  localparam int SYNC_DEPTH_MIN = 2;
endpackage

// File: rtl/lj_tx_sync.sv
module lj_tx_sync #(
  parameter int N      = 2,
  parameter int STAGES = lj_tx_pkg::SYNC_DEPTH_MIN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/lj_tx_framer.sv
module lj_tx_framer
  import lj_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bclk_s,
  input  logic  fs_s,
  input  logic  port_en_i,
  input  logic  first_fall_i,
  input  logic  err_clr_i,
  input  logic  buf_full_i,
  output logic  load_o,
  output logic  shift_o,
  output logic  pop_o,
  output chan_e chan_o,
  output logic  underrun_o,
  output logic  swap_o
);
  logic  bclk_prev_q, fs_last_q, started_q, real_seen_q, underrun_q, swap_q;
  logic  bclk_prev_d, fs_last_d, started_d, real_seen_d, underrun_d, swap_d;
  chan_e chan_q, chan_d;
  logic  bclk_fall, frame_edge, edge_first;

  assign bclk_fall  = bclk_prev_q & ~bclk_s;
  assign frame_edge = bclk_fall & (fs_s ^ fs_last_q);
  assign edge_first = frame_edge & (fs_s ^ first_fall_i);

  assign load_o  = frame_edge & port_en_i & (started_q | edge_first);
  assign shift_o = bclk_fall & port_en_i & started_q & ~frame_edge;
  assign pop_o   = load_o & buf_full_i;

  always_comb begin
    bclk_prev_d = bclk_s;
    fs_last_d   = bclk_fall ? fs_s : fs_last_q;
    started_d   = started_q;
    real_seen_d = real_seen_q;
    underrun_d  = underrun_q;
    swap_d      = swap_q;
    chan_d      = chan_q;
    if (!port_en_i) begin
      started_d   = 1'b0;
      real_seen_d = 1'b0;
      underrun_d  = 1'b0;
      swap_d      = 1'b0;
      chan_d      = CH_FIRST;
    end else begin
      if (err_clr_i) begin
        underrun_d = 1'b0;
        swap_d     = 1'b0;
      end
      if (load_o) begin
        started_d = 1'b1;
        chan_d    = edge_first ? CH_FIRST : CH_SECOND;
        if (!buf_full_i) begin
          underrun_d = 1'b1;
        end else if (!real_seen_q) begin
          real_seen_d = 1'b1;
          if (!edge_first) swap_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev_q <= 1'b0;
      fs_last_q   <= 1'b0;
      started_q   <= 1'b0;
      real_seen_q <= 1'b0;
      underrun_q  <= 1'b0;
      swap_q      <= 1'b0;
      chan_q      <= CH_FIRST;
    end else begin
      bclk_prev_q <= bclk_prev_d;
      fs_last_q   <= fs_last_d;
      started_q   <= started_d;
      real_seen_q <= real_seen_d;
      underrun_q  <= underrun_d;
      swap_q      <= swap_d;
      chan_q      <= chan_d;
    end
  end

  assign chan_o     = chan_q;
  assign underrun_o = underrun_q;
  assign swap_o     = swap_q;

  AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started_q) |-> $past(edge_first)); // R3
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_q && port_en_i && !err_clr_i) |=> underrun_q); // R5
  AST_SWAP_ON_REAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swap_q) |-> $past(buf_full_i && frame_edge)); // R8
  AST_FLAGS_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en_i |=> (!underrun_q && !swap_q)); // R5
endmodule

// File: rtl/lj_tx_holdbuf.sv
module lj_tx_holdbuf #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en_i,
  input  logic              wr_valid_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  input  logic              pop_i,
  output logic              full_o,
  output logic [WORD_W-1:0] word_o
);
  logic              full_q, full_d;
  logic [WORD_W-1:0] data_q, data_d, last_q, last_d;
  logic              push;

  assign wr_ready_o = fill_en_i & ~full_q;
  assign push       = wr_valid_i & wr_ready_o;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    last_d = last_q;
    if (push) begin
      full_d = 1'b1;
      data_d = wr_data_i;
    end else if (pop_i) begin
      full_d = 1'b0;
      last_d = data_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      last_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
      last_q <= last_d;
    end
  end

  assign full_o = full_q;
  assign word_o = full_q ? data_q : last_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !pop_i) |=> (full_q && $stable(data_q))); // R4
  AST_NO_FILL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en_i |=> !$rose(full_q)); // R9
endmodule

// File: rtl/lj_tx_shifter.sv
module lj_tx_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en_i,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sdata_o
);
  logic [WORD_W-1:0] shreg_q, shreg_d;

  always_comb begin
    shreg_d = shreg_q;
    if (!port_en_i)   shreg_d = '0;
    else if (load_i)  shreg_d = word_i;
    else if (shift_i) shreg_d = {shreg_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  assign sdata_o = shreg_q[WORD_W-1];

  AST_SHREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en_i && !load_i && !shift_i) |=> $stable(shreg_q)); // R1
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en_i |=> !sdata_o); // R2
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en_i && shift_i) |=> !shreg_q[0]); // R2
endmodule

// File: rtl/lj_audio_tx.sv
module lj_audio_tx
  import lj_tx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_in,
  input  logic              fs_in,
  input  logic              port_en,
  input  logic              fill_en,
  input  logic              first_on_fall,
  input  logic              err_clr,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              sdata_o,
  output logic              chan_o,
  output logic              underrun_o,
  output logic              swap_o
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] pins_s;
  logic              load, shift, pop, buf_full;
  logic [WORD_W-1:0] word;
  chan_e             chan;

  lj_tx_sync #(.N(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({fs_in, bclk_in}), .sync_o(pins_s)
  );

  lj_tx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .bclk_s(pins_s[0]), .fs_s(pins_s[1]),
    .port_en_i(port_en), .first_fall_i(first_on_fall), .err_clr_i(err_clr),
    .buf_full_i(buf_full), .load_o(load), .shift_o(shift), .pop_o(pop),
    .chan_o(chan), .underrun_o(underrun_o), .swap_o(swap_o)
  );

  lj_tx_holdbuf #(.WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .fill_en_i(fill_en), .wr_valid_i(wr_valid),
    .wr_data_i(wr_data), .wr_ready_o(wr_ready), .pop_i(pop),
    .full_o(buf_full), .word_o(word)
  );

  lj_tx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .port_en_i(port_en), .load_i(load),
    .shift_i(shift), .word_i(word), .sdata_o(sdata_o)
  );

  assign chan_o = (chan == CH_SECOND);
endmodule

// File: tb/lj_audio_tx_tb.sv
`timescale 1ns/1ps
module lj_audio_tx_tb;
  localparam int W    = 16;
  localparam int SLOT = 20;
  localparam int HB   = 4;

  logic clk = 1'b0;
  logic rst_n, bclk, fs, port_en, fill_en, first_on_fall, err_clr;
  logic wr_ready, sdata, chan, underrun, swap;
  logic wr_valid;
  logic [W-1:0] wr_data;
  int feed_idx = 0;
  int feed_lim = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] word_of(input int i);
    logic [W-1:0] k;
    k = W'(i);
    return 16'h8001 ^ (k * 16'h1357);
  endfunction

  function automatic logic [SLOT-1:0] pad(input logic [W-1:0] w);
    return {w, {(SLOT-W){1'b0}}};
  endfunction

  assign wr_valid = (feed_idx < feed_lim);
  assign wr_data  = word_of(feed_idx);

  lj_audio_tx #(.WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fs_in(fs), .port_en(port_en),
    .fill_en(fill_en), .first_on_fall(first_on_fall), .err_clr(err_clr),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .sdata_o(sdata), .chan_o(chan), .underrun_o(underrun), .swap_o(swap)
  );

  initial begin
    forever begin
      bit acc;
      @(negedge clk);
      acc = wr_valid && wr_ready && rst_n;
      @(posedge clk);
      #1;
      if (acc) feed_idx++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half(input logic fsv, input logic [SLOT-1:0] exp, input string req);
    logic [SLOT-1:0] got;
    for (int b = 0; b < SLOT; b++) begin
      @(negedge clk);
      bclk = 1'b0;
      if (b == 0) fs = fsv;
      repeat (HB) @(negedge clk);
      bclk = 1'b1;
      repeat (HB-1) @(negedge clk);
      got[SLOT-1-b] = sdata;
    end
    chk(got == exp, req, 32'(got), 32'(exp));
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 0; bclk = 1; fs = 0; port_en = 0; fill_en = 0;
    first_on_fall = 0; err_clr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(sdata == 0, "R2 reset sdata", 32'(sdata), 0);
    chk(underrun == 0, "R5 reset underrun", 32'(underrun), 0);
    chk(swap == 0, "R8 reset swap", 32'(swap), 0);
    chk(chan == 0, "R7 reset chan", 32'(chan), 0);
    chk(wr_ready == 0, "R9 reset ready", 32'(wr_ready), 0);

    // Hazard: port enabled before the buffer is filled; the producer is already valid
    feed_lim = 100;
    port_en = 1;
    repeat (4) @(negedge clk);
    chk(wr_ready == 0, "R9 ready low while fill off", 32'(wr_ready), 0);
    half(1'b1, '0, "R6 stale zero on first edge");
    chk(underrun == 1, "R5 underrun set", 32'(underrun), 1);
    chk(chan == 0, "R7 first-edge tag", 32'(chan), 0);
    fill_en = 1;
    repeat (6) @(negedge clk);
    chk(wr_ready == 0, "R4 word waits in buffer", 32'(wr_ready), 0);
    chk(sdata == 0, "R4 no mid-frame load", 32'(sdata), 0);
    half(1'b0, pad(word_of(0)), "R1 word0 on opposite edge");
    chk(chan == 1, "R7 word0 tagged second", 32'(chan), 1);
    chk(swap == 1, "R8 swap flagged", 32'(swap), 1);
    half(1'b1, pad(word_of(1)), "R1 word1");
    chk(chan == 0, "R7 word1 tag", 32'(chan), 0);
    half(1'b0, pad(word_of(2)), "R2 word2 zero pad");
    fill_en = 0;
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
    chk(underrun == 0, "R5 err_clr clears underrun", 32'(underrun), 0);
    chk(swap == 0, "R8 err_clr clears swap", 32'(swap), 0);
    port_en = 0;
    half(1'b1, '0, "R2 quiet while disabled");

    // Correct order: buffer already holds word3; first channel on the falling edge
    first_on_fall = 1;
    feed_lim = 7;
    fill_en = 1;
    half(1'b0, '0, "R2 quiet before enable");
    port_en = 1;
    half(1'b1, '0, "R3 non-qualifying edge ignored");
    chk(wr_ready == 0, "R3 buffer still held", 32'(wr_ready), 0);
    half(1'b0, pad(word_of(3)), "R3 start on falling edge");
    chk(chan == 0, "R7 falling is first", 32'(chan), 0);
    half(1'b1, pad(word_of(4)), "R1 word4");
    chk(chan == 1, "R7 rising is second", 32'(chan), 1);
    half(1'b0, pad(word_of(5)), "R1 word5");
    half(1'b1, pad(word_of(6)), "R1 word6");
    chk(underrun == 0, "R5 no underrun in order", 32'(underrun), 0);
    half(1'b0, pad(word_of(6)), "R6 repeat last word");
    chk(underrun == 1, "R5 underrun on empty", 32'(underrun), 1);
    chk(swap == 0, "R8 no swap in order", 32'(swap), 0);
    port_en = 0;
    repeat (3) @(negedge clk);
    chk(underrun == 0, "R5 disable clears underrun", 32'(underrun), 0);
    chk(sdata == 0, "R2 disable quiets output", 32'(sdata), 0);
    report();
  end
endmodule